// File: doc/BRIEF.md
# Memory-Mapped Network Port Bridge

This block sits between a 32-bit processor load/store bus and the local injection and ejection port of a network router. It claims the two highest word addresses of the processor's physical address space. The topmost word is the data word and the word just below it is the control/status word. Every other bus access passes straight through to local memory, unchanged and undecoded.

To send, software writes the payload to the data word. It then writes the control/status word with the destination node in bits 15:8 and bit 0 set. The block presents the flit to the router with a valid/ready handshake, and bit 0 reads back as 1 until the router takes the flit. To receive, software polls bit 1 of the status word and then reads the data word. That read frees the receive slot so that the router may deliver the next word.

The outgoing and incoming words are held in separate registers behind the one data address. A word that arrives from the network therefore never overwrites a payload that is still waiting to leave.

Top module: `memnet_bridge`

## Requirements
- R1: The data word is at the word address with all address bits 2 and above set (0xFFFC for a 16-bit address). The status word is 4 bytes below it (0xFFF8). An access to either address raises no memory request. Any other access drives mem_req, mem_we, mem_addr and mem_wdata from the processor bus in the same cycle, and returns mem_rdata on cpu_rdata.
- R2: A write to the data word while no send is pending stores the word. From the next cycle it appears on tx_data.
- R3: A status write with bit 0 = 1 while no send is pending raises tx_valid from the next cycle. tx_dest then equals bits 15:8 of that write, and status bit 0 reads 1.
- R4: In the cycle after a cycle with tx_valid and tx_ready both high, tx_valid is low and status bit 0 reads 0.
- R5: While a send is pending, writes to the data word and writes to the status word are ignored. tx_data, tx_dest and tx_valid keep their values.
- R6: rx_ready is high while the receive slot is empty. After a cycle with rx_valid and rx_ready both high, rx_ready is low, status bit 1 reads 1, and a data-word read returns the accepted word.
- R7: While the slot is full, further rx_valid is not accepted. A read of the data word while it is full empties the slot from the next cycle: status bit 1 reads 0 and rx_ready is high.
- R8: Accepting a received word leaves tx_data unchanged.
- R9: After reset, tx_valid is low, rx_ready is high, and the status word reads 0.
- R10: The status word reads with bit 0 = send pending, bit 1 = receive valid, bits 15:8 = stored destination, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor bus access strobe |
| cpu_we | input | 1 | Write enable of the access |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data (combinational) |
| mem_req | output | 1 | Access strobe forwarded to memory |
| mem_we | output | 1 | Forwarded write enable |
| mem_addr | output | AW | Forwarded address |
| mem_wdata | output | 32 | Forwarded write data |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Router accepts outgoing flit |
| tx_dest | output | 8 | Destination node of the flit |
| tx_data | output | 32 | Outgoing payload |
| rx_valid | input | 1 | Router offers a received word |
| rx_ready | output | 1 | Receive slot is empty |
| rx_data | input | 32 | Received word |

## Verification
Read data and memory pass-through are combinational, so the bench samples them in the same cycle as the access, shortly after driving it at the falling edge. Every register effect is due one rising edge later: a data or status write, a send handshake, a receive handshake and a data read that empties the slot. The bench therefore checks each of these at the falling edge that follows that rising edge. Destinations and payloads are swept over many values, and the bench computes the expected status word arithmetically from the bit layout.

// File: rtl/mnb_pkg.sv
package mnb_pkg;
    localparam int WORD_W = 32;
    localparam int NODE_W = 8;

    typedef enum logic [1:0] {
        SEL_MEM  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2
    } sel_e;

    typedef struct packed {
        logic [15:0]       pad_hi;
        logic [NODE_W-1:0] node;
        logic [5:0]        pad_lo;
        logic              rx_full;
        logic              tx_busy;
    } stat_word_t;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic [NODE_W-1:0] node,
        input logic              rx_full,
        input logic              tx_busy
    );
        stat_word_t s;
        s         = '0;
        s.node    = node;
        s.rx_full = rx_full;
        s.tx_busy = tx_busy;
        return s;
    endfunction

    function automatic logic [NODE_W-1:0] status_node(input logic [WORD_W-1:0] w);
        stat_word_t s;
        s = w;
        return s.node;
    endfunction

    function automatic logic status_go(input logic [WORD_W-1:0] w);
        stat_word_t s;
        s = w;
        return s.tx_busy;
    endfunction
endpackage

// File: rtl/mnb_decode.sv
module mnb_decode #(
    parameter int AW = 16
) (
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    output mnb_pkg::sel_e sel,
    output logic          wr_stat,
    output logic          wr_data,
    output logic          rd_data,
    output logic          mem_req
);
    localparam int WA = AW - 2;
    localparam logic [WA-1:0] DATA_WA = {WA{1'b1}};
    localparam logic [WA-1:0] STAT_WA = DATA_WA - 1'b1;

    logic [WA-1:0] wa;
    assign wa = cpu_addr[AW-1:2];

    always_comb begin
        if (wa == DATA_WA)      sel = mnb_pkg::SEL_DATA;
        else if (wa == STAT_WA) sel = mnb_pkg::SEL_STAT;
        else                    sel = mnb_pkg::SEL_MEM;
    end

    assign wr_stat = cpu_req &&  cpu_we && (sel == mnb_pkg::SEL_STAT);
    assign wr_data = cpu_req &&  cpu_we && (sel == mnb_pkg::SEL_DATA);
    assign rd_data = cpu_req && !cpu_we && (sel == mnb_pkg::SEL_DATA);
    assign mem_req = cpu_req && (sel == mnb_pkg::SEL_MEM);
endmodule

// File: rtl/mnb_tx.sv
module mnb_tx
    import mnb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_data,
    input  logic              wr_stat,
    input  logic [WORD_W-1:0] wdata,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [NODE_W-1:0] tx_dest,
    output logic [WORD_W-1:0] tx_data
);
    logic              busy_q;
    logic [NODE_W-1:0] node_q;
    logic [WORD_W-1:0] pay_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            node_q <= '0;
            pay_q  <= '0;
        end else if (busy_q) begin
            if (tx_ready) busy_q <= 1'b0;
        end else begin
            if (wr_data) pay_q <= wdata;
            if (wr_stat) begin
                node_q <= status_node(wdata);
                busy_q <= status_go(wdata);
            end
        end
    end

    assign tx_valid = busy_q;
    assign tx_dest  = node_q;
    assign tx_data  = pay_q;
endmodule

// File: rtl/mnb_rx.sv
module mnb_rx
    import mnb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              take,
    output logic              rx_ready,
    output logic              full,
    output logic [WORD_W-1:0] held
);
    logic              full_q;
    logic [WORD_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            held_q <= '0;
        end else if (full_q) begin
            if (take) full_q <= 1'b0;
        end else if (rx_valid) begin
            full_q <= 1'b1;
            held_q <= rx_data;
        end
    end

    assign rx_ready = !full_q;
    assign full     = full_q;
    assign held     = held_q;
endmodule

// File: rtl/memnet_bridge.sv
module memnet_bridge
    import mnb_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [NODE_W-1:0] tx_dest,
    output logic [WORD_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [WORD_W-1:0] rx_data
);
    sel_e              sel;
    logic              wr_stat, wr_data, rd_data;
    logic              rx_full;
    logic [WORD_W-1:0] rx_held;

    mnb_decode #(.AW(AW)) u_dec (
        .cpu_req (cpu_req),
        .cpu_we  (cpu_we),
        .cpu_addr(cpu_addr),
        .sel     (sel),
        .wr_stat (wr_stat),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .mem_req (mem_req)
    );

    mnb_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .wr_data (wr_data),
        .wr_stat (wr_stat),
        .wdata   (cpu_wdata),
        .tx_ready(tx_ready),
        .tx_valid(tx_valid),
        .tx_dest (tx_dest),
        .tx_data (tx_data)
    );

    mnb_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .take    (rd_data),
        .rx_ready(rx_ready),
        .full    (rx_full),
        .held    (rx_held)
    );

    assign mem_we    = cpu_we;
    assign mem_addr  = cpu_addr;
    assign mem_wdata = cpu_wdata;

    always_comb begin
        case (sel)
            SEL_DATA: cpu_rdata = rx_held;
            SEL_STAT: cpu_rdata = pack_status(tx_dest, rx_full, tx_valid);
            default:  cpu_rdata = mem_rdata;
        endcase
    end
endmodule

// File: rtl/mnb_chk.sv
module mnb_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic [AW-1:0] cpu_addr,
    input logic          mem_req,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_dest,
    input logic [31:0]   tx_data,
    input logic          rx_valid,
    input logic          rx_ready
);
    localparam logic [AW-3:0] TOP_WA = {(AW-2){1'b1}};

    // R1
    map_top_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_addr[AW-1:2] == TOP_WA) |-> !mem_req);

    // R4
    tx_done_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_valid);

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_dest)));

    // R6
    rx_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready) |=> !rx_ready);

    // R7
    rx_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_ready && cpu_req && !cpu_we && cpu_addr[AW-1:2] == TOP_WA) |=> rx_ready);

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_valid && rx_ready));
endmodule

bind memnet_bridge mnb_chk #(.AW(AW)) u_mnb_chk (
    .clk     (clk),
    .rst     (rst),
    .cpu_req (cpu_req),
    .cpu_we  (cpu_we),
    .cpu_addr(cpu_addr),
    .mem_req (mem_req),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_dest (tx_dest),
    .tx_data (tx_data),
    .rx_valid(rx_valid),
    .rx_ready(rx_ready)
);

// File: tb/test_memnet_bridge.sv
`timescale 1ns/1ps
module test_memnet_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam logic [AW-1:0] DATA_A = 16'hFFFC;
    localparam logic [AW-1:0] STAT_A = 16'hFFF8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]   cpu_wdata = '0, cpu_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata = '0;
    logic          tx_valid, tx_ready = 1'b0;
    logic [7:0]    tx_dest;
    logic [31:0]   tx_data;
    logic          rx_valid = 1'b0, rx_ready;
    logic [31:0]   rx_data = '0;

    int errors = 0, checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memnet_bridge #(.AW(AW)) i_memnet_bridge (
        .clk, .rst, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
        .tx_valid, .tx_ready, .tx_dest, .tx_data,
        .rx_valid, .rx_ready, .rx_data
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] st(input logic [7:0] d, input logic rv, input logic bz);
        return (32'(d) << 8) | (32'(rv) << 1) | 32'(bz);
    endfunction

    // Drives at falling edge, one rising edge, returns at next falling edge.
    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_req = 0;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [31:0] d);
        cpu_req = 0; cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        chk("R9 tx_valid", 32'(tx_valid), 0);
        chk("R9 rx_ready", 32'(rx_ready), 1);
        peek(STAT_A, r); chk("R9 status", r, 0);

        // R1 pass-through sweep over low and near-top addresses
        for (int i = 0; i < 64; i++) begin
            logic [AW-1:0] a;
            a = (i < 32) ? AW'(i * 1020) : AW'(16'hFFF4 - (i - 32) * 4);
            mem_rdata = 32'hA5000000 + i;
            cpu_req = 1; cpu_we = i[0]; cpu_addr = a; cpu_wdata = 32'h1234 + i;
            #1;
            chk("R1 mem_req", 32'(mem_req), 1);
            chk("R1 mem_addr", 32'(mem_addr), 32'(a));
            chk("R1 mem_we", 32'(mem_we), 32'(i[0]));
            chk("R1 mem_wdata", mem_wdata, 32'h1234 + i);
            chk("R1 rdata", cpu_rdata, 32'hA5000000 + i);
            cpu_req = 0;
            @(negedge clk);
        end
        cpu_req = 1; cpu_we = 0; cpu_addr = STAT_A; #1;
        chk("R1 stat no mem", 32'(mem_req), 0);
        cpu_addr = DATA_A; #1;
        chk("R1 data no mem", 32'(mem_req), 0);
        cpu_req = 0;
        @(negedge clk);

        // Send sweep: R2 R3 R4 R5 R10
        for (int d = 0; d < 256; d += 15) begin
            logic [31:0] pay;
            pay = 32'h9E3779B9 * (d + 1);
            bus_wr(DATA_A, pay);
            chk("R2 tx_data", tx_data, pay);
            chk("R2 idle", 32'(tx_valid), 0);
            bus_wr(STAT_A, 32'hFFFF_0000 | (32'(d) << 8) | 32'h1);
            chk("R3 tx_valid", 32'(tx_valid), 1);
            chk("R3 tx_dest", 32'(tx_dest), 32'(d));
            peek(STAT_A, r); chk("R10 status busy", r, st(8'(d), 0, 1));
            bus_wr(DATA_A, ~pay);
            chk("R5 data ignored", tx_data, pay);
            bus_wr(STAT_A, 32'h0000_5A01);
            chk("R5 dest kept", 32'(tx_dest), 32'(d));
            chk("R5 still valid", 32'(tx_valid), 1);
            tx_ready = 1;
            @(negedge clk);
            tx_ready = 0;
            chk("R4 tx_valid low", 32'(tx_valid), 0);
            peek(STAT_A, r); chk("R4 status", r, st(8'(d), 0, 0));
        end
        // R3 status write with bit0=0 only updates destination
        bus_wr(STAT_A, 32'h0000_3C00);
        chk("R3 no send", 32'(tx_valid), 0);
        chk("R3 dest set", 32'(tx_dest), 32'h3C);

        // Receive sweep: R6 R7 R8 R10
        for (int k = 0; k < 20; k++) begin
            logic [31:0] w, txs;
            w = 32'hC0DE0000 ^ (32'(k) * 32'h01010101);
            txs = tx_data;
            chk("R6 ready empty", 32'(rx_ready), 1);
            rx_valid = 1; rx_data = w;
            @(negedge clk);
            rx_data = ~w;
            chk("R6 ready low", 32'(rx_ready), 0);
            chk("R8 tx_data kept", tx_data, txs);
            peek(STAT_A, r); chk("R6 status", r, st(8'h3C, 1, 0));
            @(negedge clk); // second offer while full
            rx_valid = 0;
            bus_rd(DATA_A, r);
            chk("R7 no overwrite / R6 data", r, w);
            chk("R7 ready again", 32'(rx_ready), 1);
            peek(STAT_A, r); chk("R7 status cleared", r, st(8'h3C, 0, 0));
        end

        // R9 reset mid-traffic
        bus_wr(STAT_A, 32'h0000_7701);
        rx_valid = 1; rx_data = 32'h55;
        @(negedge clk);
        rx_valid = 0;
        rst = 1; @(negedge clk); rst = 0;
        chk("R9 tx after rst", 32'(tx_valid), 0);
        chk("R9 rx after rst", 32'(rx_ready), 1);
        peek(STAT_A, r); chk("R9 status after rst", r, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule